// File: doc/BRIEF.md
# Escalating Three-Stage Watchdog Supervisor

This block supervises the software running on one processing module of a redundant computer. Software proves it is alive by pulsing a kick strobe before a programmable number of clock cycles runs out. The first missed interval raises an interrupt to the local processor. A second missed interval starts a fixed-length initialisation reset pulse that restarts the module. The watchdog then gives the restarted software one more full interval to show it has recovered. A kick inside that window counts as the recovery acknowledgement. If no kick arrives, the watchdog latches the module's failure flag.

The failure flag is meant to be wired to the peer modules. There it acts as an interrupt, and it also drives the switches that take the module out of the mesh and loop its input links through to its output links. A kick cannot clear the latched flag. Only a power-on reset or a clear command from the ground can remove it. The block also takes in the failure flags of its peers. It presents their combined state as an interrupt, and it issues a one-cycle system reset request whenever any flag in the system, including its own, becomes active. A 2-bit status code reports the current escalation stage.

Top module: `wdog_escalator`

## Requirements
- R1: When `rst_n` is sampled low, the block enters a reset state with `status_o` = 2'b00 and with `irq_o`, `init_rst_o`, `fail_o`, `peer_irq_o` and `sys_rst_o` all low. The interval counter is loaded with the full timeout on the reset edge.
- R2: Suppose the last kick (or reset) is sampled on clock edge E and no kick follows. Then `irq_o` goes high and `status_o` becomes 2'b01 after edge E+T, where T is `timeout_i`. A `timeout_i` of zero acts as one.
- R3: A kick sampled in the normal (2'b00) or interrupt (2'b01) stage returns the status to 2'b00 and clears `irq_o` on that edge. It also reloads the full interval.
- R4: Suppose a full interval expires while in the interrupt stage, on edge X. Then `status_o` becomes 2'b10, `irq_o` drops and `init_rst_o` goes high, all after edge X. `init_rst_o` stays high for exactly PULSE_LEN cycles (16 by default).
- R5: A kick sampled while `init_rst_o` is high has no effect. The status stays 2'b10 and the pulse runs its full length.
- R6: The pulse ends on edge P (the edge that takes `init_rst_o` low). A full interval starts at P. A kick sampled on any edge up to and including P+T returns the status to 2'b00, and `fail_o` stays low.
- R7: If no kick is sampled in the window after P, `fail_o` goes high and `status_o` becomes 2'b11 after edge P+T.
- R8: Once `fail_o` is high, kicks and further timeouts leave it high. It clears only on `rst_n` low or on `fail_clr_i` sampled high. The clear returns the status to 2'b00 and starts a full interval on the same edge.
- R9: When a kick and an interval expiry are sampled on the same edge, the kick wins. The stage returns to 2'b00 instead of escalating.
- R10: `peer_irq_o` is the OR of `peer_fail_i` as registered on the previous edge. `sys_rst_o` is high for exactly one cycle, one edge after any flag (a registered peer flag or `fail_o`) rises. This holds even if another flag is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| kick_i | input | 1 | Service strobe from software; also acts as the recovery acknowledgement after a restart |
| timeout_i | input | TMO_W | Interval length in clock cycles (0 acts as 1) |
| fail_clr_i | input | 1 | Ground command that clears a latched failure |
| peer_fail_i | input | NPEER | Failure flags of the peer modules |
| irq_o | output | 1 | Interrupt request to the local processor (first stage) |
| init_rst_o | output | 1 | Local initialisation reset pulse (second stage) |
| fail_o | output | 1 | Latched failure flag, for the peers and the link bypass switches |
| status_o | output | 2 | Stage code: 00 normal, 01 interrupt pending, 10 restarted, 11 failed |
| peer_irq_o | output | 1 | Interrupt raised by any peer failure flag |
| sys_rst_o | output | 1 | One-cycle system reset request on any flag rising |

## Verification
The colliding pair is a software kick and an interval expiry. The bench raises the kick one cycle before the computed expiry edge, so that both are sampled together. It does this once in the normal stage and once at the last edge of the post-restart window. In both cases it expects status 2'b00 on that edge and no interrupt or failure afterwards. A second collision lands a peer flag rising while another flag is already high. The bench judges it by expecting a fresh one-cycle system reset pulse.

// File: rtl/wdog_esc_pkg.sv
// Package: shared stage encoding for the escalating watchdog.
// Assumes: the 2-bit code is presented on a status port and decoded by software.
package wdog_esc_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL  = 2'b00,
        ST_IRQ     = 2'b01,
        ST_RESTART = 2'b10,
        ST_FAILED  = 2'b11
    } wd_stage_e;

endpackage

// File: rtl/wdog_countdown.sv
// Module: interval down-counter.
// Counts the remaining cycles of the current service interval. It flags expiry
// when one cycle is left, then reloads itself. An explicit reload (kick, pulse
// hold, failure clear) overrides the count.
// Assumes: timeout_i is stable while in use; a zero timeout is treated as one.
module wdog_countdown #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_i,
    input  logic [TMO_W-1:0] timeout_i,
    output logic             expire_o
);

    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W-1:0] load_val;

    // Purpose: clamp the programmed interval to a minimum of one cycle.
    always_comb begin
        load_val = (timeout_i == '0) ? TMO_W'(1) : timeout_i;
    end

    // Purpose: expiry is the last remaining cycle of the interval.
    always_comb begin
        expire_o = (cnt_q == TMO_W'(1));
    end

    // Purpose: reload on reset, request or expiry; otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= load_val;
        end else if (reload_i || expire_o) begin
            cnt_q <= load_val;
        end else begin
            cnt_q <= cnt_q - TMO_W'(1);
        end
    end

    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cnt_q != '0)); // R2

endmodule

// File: rtl/wdog_pulse.sv
// Module: local initialisation reset pulse generator.
// One start strobe produces exactly LEN cycles of active output.
// Assumes: the stage sequencer never restarts the pulse while it is running.
module wdog_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o
);

    localparam int PCW = $clog2(LEN + 1);

    logic [PCW-1:0] pcnt_q;

    // Purpose: output is high while cycles of the pulse remain.
    always_comb begin
        active_o = (pcnt_q != '0);
    end

    // Purpose: load the full length on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (start_i) begin
            pcnt_q <= PCW'(LEN);
        end else if (active_o) begin
            pcnt_q <= pcnt_q - PCW'(1);
        end
    end

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= PCW'(LEN)); // R4

    AST_PULSE_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_i && active_o)); // R5

endmodule

// File: rtl/wdog_stage_fsm.sv
// Module: escalation stage sequencer.
// Moves normal -> interrupt -> restart -> failed on successive expiries. A
// kick wins over a simultaneous expiry. Kicks are ignored while the local
// reset pulse runs and once the failure state is reached; only a clear
// command leaves the failure state.
// Assumes: expire_i comes from the interval counter, which is held reloaded
// during the pulse.
module wdog_stage_fsm
    import wdog_esc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      kick_i,
    input  logic      expire_i,
    input  logic      pulse_busy_i,
    input  logic      fail_clr_i,
    output wd_stage_e stage_o,
    output logic      pulse_go_o
);

    wd_stage_e stage_q;
    wd_stage_e stage_d;

    // Purpose: next-stage decision with kick priority over expiry.
    always_comb begin
        stage_d    = stage_q;
        pulse_go_o = 1'b0;
        unique case (stage_q)
            ST_NORMAL: begin
                if (!kick_i && expire_i) begin
                    stage_d = ST_IRQ;
                end
            end
            ST_IRQ: begin
                if (kick_i) begin
                    stage_d = ST_NORMAL;
                end else if (expire_i) begin
                    stage_d    = ST_RESTART;
                    pulse_go_o = 1'b1;
                end
            end
            ST_RESTART: begin
                if (!pulse_busy_i) begin
                    if (kick_i) begin
                        stage_d = ST_NORMAL;
                    end else if (expire_i) begin
                        stage_d = ST_FAILED;
                    end
                end
            end
            ST_FAILED: begin
                if (fail_clr_i) begin
                    stage_d = ST_NORMAL;
                end
            end
            default: stage_d = ST_NORMAL;
        endcase
    end

    // Purpose: stage register, cleared by power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= ST_NORMAL;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign stage_o = stage_q;

    AST_KICK_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_i && (stage_q == ST_NORMAL || stage_q == ST_IRQ)) |=> (stage_q == ST_NORMAL)); // R3

    AST_RESTART_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == ST_IRQ && expire_i && !kick_i) |=> (stage_q == ST_RESTART && pulse_busy_i)); // R4

    AST_KICK_IGNORED_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == ST_RESTART && pulse_busy_i) |=> (stage_q == ST_RESTART)); // R5

    AST_FAIL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == ST_RESTART && !pulse_busy_i && expire_i && !kick_i) |=> (stage_q == ST_FAILED)); // R7

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == ST_FAILED && !fail_clr_i) |=> (stage_q == ST_FAILED)); // R8

endmodule

// File: rtl/wdog_flag_fanin.sv
// Module: system failure-flag combiner.
// Registers the peer flags into an interrupt and requests a one-cycle system
// reset whenever any flag (own or peer) becomes active.
// Assumes: peer flags are synchronous to clk.
module wdog_flag_fanin #(
    parameter int NPEER = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             own_fail_i,
    input  logic [NPEER-1:0] peer_fail_i,
    output logic             peer_irq_o,
    output logic             sys_rst_o
);

    localparam int NFLAG = NPEER + 1;

    logic [NPEER-1:0] peer_q;
    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] flags_prev_q;
    logic             sys_rst_q;

    // Purpose: gather all flags of the system into one vector.
    always_comb begin
        flags = {peer_q, own_fail_i};
    end

    // Purpose: register peers, remember flags, pulse on any rising flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peer_q       <= '0;
            flags_prev_q <= '0;
            sys_rst_q    <= 1'b0;
        end else begin
            peer_q       <= peer_fail_i;
            flags_prev_q <= flags;
            sys_rst_q    <= |(flags & ~flags_prev_q);
        end
    end

    assign peer_irq_o = |peer_q;
    assign sys_rst_o  = sys_rst_q;

    AST_SYSRST_ON_OWN_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_fail_i) |=> sys_rst_o); // R10

    AST_SYSRST_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_o && $past(sys_rst_o)) |-> $past(|(flags & ~flags_prev_q))); // R10

endmodule

// File: rtl/wdog_escalator.sv
// Module: escalating three-stage watchdog supervisor (top).
// Ties the interval counter, the stage sequencer, the reset pulse generator
// and the system flag combiner together. The counter is held reloaded while
// the local reset pulse runs, so the recovery window starts when the pulse ends.
// Assumes: synchronous active-low power-on reset; all inputs synchronous to clk.
module wdog_escalator
    import wdog_esc_pkg::*;
#(
    parameter int TMO_W     = 16,
    parameter int PULSE_LEN = 16,
    parameter int NPEER     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick_i,
    input  logic [TMO_W-1:0] timeout_i,
    input  logic             fail_clr_i,
    input  logic [NPEER-1:0] peer_fail_i,
    output logic             irq_o,
    output logic             init_rst_o,
    output logic             fail_o,
    output logic [1:0]       status_o,
    output logic             peer_irq_o,
    output logic             sys_rst_o
);

    logic      expire;
    logic      pulse_busy;
    logic      pulse_go;
    logic      cnt_reload;
    wd_stage_e stage;

    // Purpose: restart the interval on kicks, during the pulse and on clear.
    always_comb begin
        cnt_reload = kick_i || pulse_busy || fail_clr_i;
    end

    wdog_countdown #(
        .TMO_W (TMO_W)
    ) u_countdown (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload_i  (cnt_reload),
        .timeout_i (timeout_i),
        .expire_o  (expire)
    );

    wdog_stage_fsm u_stage (
        .clk          (clk),
        .rst_n        (rst_n),
        .kick_i       (kick_i),
        .expire_i     (expire),
        .pulse_busy_i (pulse_busy),
        .fail_clr_i   (fail_clr_i),
        .stage_o      (stage),
        .pulse_go_o   (pulse_go)
    );

    wdog_pulse #(
        .LEN (PULSE_LEN)
    ) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (pulse_go),
        .active_o (pulse_busy)
    );

    // Purpose: decode the stage into the module's outputs.
    always_comb begin
        irq_o      = (stage == ST_IRQ);
        fail_o     = (stage == ST_FAILED);
        init_rst_o = pulse_busy;
        status_o   = stage;
    end

    wdog_flag_fanin #(
        .NPEER (NPEER)
    ) u_fanin (
        .clk         (clk),
        .rst_n       (rst_n),
        .own_fail_i  (fail_o),
        .peer_fail_i (peer_fail_i),
        .peer_irq_o  (peer_irq_o),
        .sys_rst_o   (sys_rst_o)
    );

    AST_PULSE_ONLY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        init_rst_o |-> (status_o == 2'b10)); // R4

    AST_CLEAR_LEAVES_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && fail_clr_i) |=> (status_o == 2'b00)); // R8

endmodule

// File: tb/test_wdog_escalator.sv
module test_wdog_escalator;

    localparam int TMO_W = 16;
    localparam int PLEN  = 16;
    localparam int NPEER = 2;
    localparam int T     = 6;

    localparam int S_STATUS = 0;
    localparam int S_IRQ    = 1;
    localparam int S_INIT   = 2;
    localparam int S_FAIL   = 3;
    localparam int S_SYSRST = 4;
    localparam int S_PEER   = 5;

    typedef struct {
        int    at;
        int    sel;
        int    val;
        string req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             kick = 1'b0;
    logic [TMO_W-1:0] tmo = TMO_W'(T);
    logic             fail_clr = 1'b0;
    logic [NPEER-1:0] peer = '0;
    logic             irq, init_rst, fail, peer_irq, sys_rst;
    logic [1:0]       status;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sbq[$];
    exp_t keep[$];

    wdog_escalator #(
        .TMO_W     (TMO_W),
        .PULSE_LEN (PLEN),
        .NPEER     (NPEER)
    ) i_wdog_escalator (
        .clk         (clk),
        .rst_n       (rst_n),
        .kick_i      (kick),
        .timeout_i   (tmo),
        .fail_clr_i  (fail_clr),
        .peer_fail_i (peer),
        .irq_o       (irq),
        .init_rst_o  (init_rst),
        .fail_o      (fail),
        .status_o    (status),
        .peer_irq_o  (peer_irq),
        .sys_rst_o   (sys_rst)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int probe(int sel);
        case (sel)
            S_STATUS: return int'(status);
            S_IRQ:    return int'(irq);
            S_INIT:   return int'(init_rst);
            S_FAIL:   return int'(fail);
            S_SYSRST: return int'(sys_rst);
            default:  return int'(peer_irq);
        endcase
    endfunction

    // Monitor: pop the items due this cycle and compare them with the outputs.
    always @(negedge clk) begin
        keep = {};
        foreach (sbq[i]) begin
            if (sbq[i].at == cyc) begin
                n_checks++;
                if (probe(sbq[i].sel) != sbq[i].val) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d sel %0d actual %0d expected %0d",
                             sbq[i].req, cyc, sbq[i].sel, probe(sbq[i].sel), sbq[i].val);
                end
            end else if (sbq[i].at < cyc) begin
                n_checks++;
                n_fail++;
                $display("FAIL %s cycle %0d missed, actual none expected %0d",
                         sbq[i].req, sbq[i].at, sbq[i].val);
            end else begin
                keep.push_back(sbq[i]);
            end
        end
        sbq = keep;
    end

    task automatic expect_at(int at, int sel, int val, string req);
        exp_t e;
        e.at = at; e.sel = sel; e.val = val; e.req = req;
        sbq.push_back(e);
    endtask

    task automatic wait_cyc(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_reset(output int r);
        @(negedge clk);
        rst_n = 1'b0; kick = 1'b0; fail_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        r = cyc;
    endtask

    task automatic pulse_kick();
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    initial begin
        int r;
        int p;
        int c;

        // R1: reset state
        do_reset(r);
        expect_at(r + 1, S_STATUS, 0, "R1");
        expect_at(r + 1, S_IRQ,    0, "R1");
        expect_at(r + 1, S_INIT,   0, "R1");
        expect_at(r + 1, S_FAIL,   0, "R1");
        expect_at(r + 1, S_SYSRST, 0, "R1");
        expect_at(r + 1, S_PEER,   0, "R1");
        // R2: interrupt exactly T edges after reset
        expect_at(r + T - 1, S_IRQ,    0, "R2");
        expect_at(r + T,     S_IRQ,    1, "R2");
        expect_at(r + T,     S_STATUS, 1, "R2");
        // R3: kick in interrupt stage
        wait_cyc(r + T + 2);
        c = cyc;
        expect_at(c + 1,     S_STATUS, 0, "R3");
        expect_at(c + 1,     S_IRQ,    0, "R3");
        expect_at(c + T,     S_IRQ,    0, "R3");
        expect_at(c + 1 + T, S_IRQ,    1, "R3");
        pulse_kick();
        wait_cyc(c + T + 4);

        // R9: kick coincides with expiry in normal stage
        do_reset(r);
        wait_cyc(r + T - 1);
        expect_at(r + T,     S_STATUS, 0, "R9");
        expect_at(r + T,     S_IRQ,    0, "R9");
        expect_at(r + 2 * T, S_IRQ,    1, "R9");
        pulse_kick();
        wait_cyc(r + 2 * T + 2);

        // R4, R5, R6, R9: restart, ignored kick, recovery at last window edge
        do_reset(r);
        p = r + 2 * T + PLEN;
        expect_at(r + 2 * T,            S_STATUS, 2, "R4");
        expect_at(r + 2 * T,            S_INIT,   1, "R4");
        expect_at(r + 2 * T + 1,        S_IRQ,    0, "R4");
        expect_at(r + 2 * T + PLEN - 1, S_INIT,   1, "R4");
        expect_at(p,                    S_INIT,   0, "R4");
        expect_at(r + 2 * T + 6,        S_STATUS, 2, "R5");
        expect_at(p - 1,                S_INIT,   1, "R5");
        wait_cyc(r + 2 * T + 4);
        pulse_kick();
        expect_at(p + T,     S_STATUS, 0, "R6 R9");
        expect_at(p + T,     S_FAIL,   0, "R6 R9");
        expect_at(p + T + 2, S_FAIL,   0, "R6");
        wait_cyc(p + T - 1);
        pulse_kick();
        wait_cyc(p + T + 4);

        // R7, R8, R10: failure, sticky flag, clear
        do_reset(r);
        p = r + 2 * T + PLEN;
        expect_at(p + T - 1, S_STATUS, 2, "R7");
        expect_at(p + T,     S_STATUS, 3, "R7");
        expect_at(p + T,     S_FAIL,   1, "R7");
        expect_at(p + T,     S_SYSRST, 0, "R10");
        expect_at(p + T + 1, S_SYSRST, 1, "R10");
        expect_at(p + T + 2, S_SYSRST, 0, "R10");
        expect_at(p + T + 5, S_FAIL,   1, "R8");
        expect_at(p + 3 * T, S_STATUS, 3, "R8");
        wait_cyc(p + T + 3);
        pulse_kick();
        wait_cyc(p + 3 * T + 1);
        c = cyc;
        expect_at(c + 1,     S_STATUS, 0, "R8");
        expect_at(c + 1,     S_FAIL,   0, "R8");
        expect_at(c + T,     S_IRQ,    0, "R8");
        expect_at(c + 1 + T, S_IRQ,    1, "R8");
        fail_clr = 1'b1;
        @(negedge clk);
        fail_clr = 1'b0;
        wait_cyc(c + T + 3);

        // R8: power-on reset clears a latched failure
        do_reset(r);
        wait_cyc(r + 2 * T + PLEN + T + 1);
        do_reset(r);
        expect_at(r + 1, S_FAIL,   0, "R8");
        expect_at(r + 1, S_STATUS, 0, "R8");
        wait_cyc(r + 2);

        // R10: peer flags, second flag rising while the first is high
        c = cyc;
        expect_at(c + 1, S_PEER,   1, "R10");
        expect_at(c + 1, S_SYSRST, 0, "R10");
        expect_at(c + 2, S_SYSRST, 1, "R10");
        expect_at(c + 3, S_SYSRST, 0, "R10");
        expect_at(c + 6, S_SYSRST, 0, "R10");
        expect_at(c + 7, S_SYSRST, 1, "R10");
        expect_at(c + 8, S_SYSRST, 0, "R10");
        peer = 2'b01;
        wait_cyc(c + 5);
        peer = 2'b11;
        wait_cyc(c + 8);
        c = cyc;
        expect_at(c + 1, S_PEER,   0, "R10");
        expect_at(c + 2, S_SYSRST, 0, "R10");
        peer = 2'b00;
        wait_cyc(c + 3);

        // R2: zero timeout acts as one cycle
        tmo = '0;
        do_reset(r);
        expect_at(r + 1, S_IRQ,    1, "R2");
        expect_at(r + 1, S_STATUS, 1, "R2");
        wait_cyc(r + 3);
        tmo = TMO_W'(T);

        wait (sbq.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired, actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule